// File: doc/BRIEF.md
# SDRAM Concurrent Auto-Precharge Bank Tracker

This block follows the registered command stream of a four-bank SDRAM and keeps a timing state machine for every bank. It sees bank activations, column reads and column writes (each with or without auto-precharge) and idle cycles. For each bank it works out when the burst finishes, when the automatic precharge begins and when the bank becomes idle again. On the data side it reports, cycle by cycle, whether the bus carries valid read data or valid write data. It also flags the cycle in which a burst is cut short.

Its central job is concurrent auto-precharge. An access to a second bank may cut into a burst that carries auto-precharge. That cut fixes when the first bank starts its precharge. For a read being cut, precharge starts at once. For a write being cut, it starts after write recovery, and the recovery is counted from the interrupting command. The block also flags two misuses. One is a command sent to a bank in the wrong state. The other is a write that takes over the bus from pending read data without the data mask having been raised beforehand.

A command presented in cycle c is registered at the clock edge that closes cycle c. Every timing below is counted from that command cycle. CAS latency, burst length, write recovery and precharge time are parameters (defaults 3, 4, 2, 3). The write-burst mode bit is a plain input that is sampled with each write.

Top module: `sdram_cap_tracker`

## Requirements
- R1: After reset every bank is idle (`bankIdle` all ones), and `preStart`, `rdValid`, `wrValid`, `burstCut`, `illegalCmd` and `contentionErr` are all low.
- R2: The command code on `cmd` is 2'b00 no-op, 2'b01 activate, 2'b10 read, 2'b11 write. A legal read in cycle c that is not cut raises `rdValid` in cycles c+CAS_LAT through c+CAS_LAT+BURST_LEN-1.
- R3: A legal read to a bank in cycle x, while another bank's auto-precharge read still has column beats left, ends that burst's data after cycle x-1+CAS_LAT. The new read's data follows on without a gap, and the cut bank's `preStart` bit is high in cycle x+1.
- R4: A legal write in cycle x that cuts an auto-precharge read of another bank sets that bank's `preStart` bit high in cycle x+1. No read data of the cut bank appears from cycle x on.
- R5: A legal read or write in cycle x that cuts an auto-precharge write of another bank makes cycle x-1 the last write-data cycle of the cut bank. The cut bank's `preStart` bit goes high in cycle x+WR_RECOV.
- R6: A legal write in cycle c raises `wrValid` in cycles c through c+W-1. W is BURST_LEN when `wrSingle` is 0 and 1 when `wrSingle` is 1. Reads keep the full burst length in both modes.
- R7: An auto-precharge burst that is not cut starts precharge in cycle c+CAS_LAT+BURST_LEN for a read, and in cycle c+W+WR_RECOV for a write.
- R8: A legal write in cycle x, while read data is in flight, raises `contentionErr` in cycle x unless `dqm` was high in both cycle x-2 and cycle x-1.
- R9: An activate to a bank that is not idle, or a read or write to a bank that is not open without a pending burst, raises `illegalCmd` in that cycle. Such a command changes no bank state and no data flag.
- R10: A bank whose `preStart` bit is high in cycle p shows `bankIdle` low through cycle p+PRE_TIME-1 and high in cycle p+PRE_TIME. An idle bank stays idle until it is activated.
- R11: `burstCut` is high in the cycle of a legal access that either cuts the column beats left in a running burst or discards read data in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmd | input | 2 | Command code of this cycle |
| bank | input | 2 | Bank addressed by the command |
| autoPre | input | 1 | Access closes its bank automatically |
| dqm | input | 1 | Data mask level of this cycle |
| wrSingle | input | 1 | Write-burst mode: writes are one beat long |
| bankIdle | output | 4 | Per-bank idle indication |
| preStart | output | 4 | Per-bank pulse in the first precharge cycle |
| rdValid | output | 1 | Bus carries valid read data this cycle |
| wrValid | output | 1 | Bus carries valid write data this cycle |
| burstCut | output | 1 | This cycle's access truncates a burst |
| illegalCmd | output | 1 | This cycle's command hits a bank in the wrong state |
| contentionErr | output | 1 | Write takes the bus from unmasked read data |

## Verification
The assertions rely on some assumptions about the inputs. They assume that `cmd` and `bank` are never unknown after reset, that at most one command arrives per cycle, and that the parameters keep write recovery at two or more cycles and precharge at one or more. The stimulus activates each bank only when it is idle. Every burst it opens carries auto-precharge, and it adds enough idle cycles after each case that all banks are closed before the next case begins. Illegal commands are sent only on purpose, at points where their expected flag is already queued.

// File: rtl/sdram_cap_pkg.sv
package sdram_cap_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_ACT = 2'b01,
    CMD_RD  = 2'b10,
    CMD_WR  = 2'b11
  } cmd_e;

  typedef enum logic [2:0] {
    BK_IDLE,
    BK_OPEN,
    BK_RDAP,
    BK_WRAP,
    BK_PRECH
  } bankState_e;

  // strobes sent from the command control to one bank timer
  typedef struct packed {
    logic openRow;
    logic startRdAp;
    logic startWrAp;
    logic cutBurst;
  } bankStrobe_t;

endpackage

// File: rtl/sdram_cap_ctrl.sv
module sdram_cap_ctrl
  import sdram_cap_pkg::*;
#(
  parameter int CAS_LAT   = 3,
  parameter int BURST_LEN = 4,
  parameter int NUM_BANKS = 4,
  localparam int BA_W  = $clog2(NUM_BANKS),
  localparam int LEN_W = $clog2(BURST_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           cmd,
  input  logic [BA_W-1:0]      bank,
  input  logic                 autoPre,
  input  logic                 dqm,
  input  logic                 wrSingle,
  input  logic [NUM_BANKS-1:0] bankIdle,
  input  logic [NUM_BANKS-1:0] bankOpen,
  output bankStrobe_t          strobes [NUM_BANKS],
  output logic                 rdValid,
  output logic                 wrValid,
  output logic                 burstCut,
  output logic                 illegalCmd,
  output logic                 contentionErr
);

  cmd_e cmdE;
  logic isAct, isRd, isWr, legal;
  logic accessNow, actNow, writeNow, streamLive, cutStream, pipeBusy, rdBeatNow;
  logic [LEN_W-1:0] colLeft, wrBeats;
  logic colWrite;
  logic [BA_W-1:0] colBank;
  logic [CAS_LAT-1:0] rdPipe;
  logic [CAS_LAT:0] pipeShift;
  logic [1:0] dqmHist;

  assign cmdE  = cmd_e'(cmd);
  assign isAct = (cmdE == CMD_ACT);
  assign isRd  = (cmdE == CMD_RD);
  assign isWr  = (cmdE == CMD_WR);

  always_comb begin
    legal = 1'b1;
    if (isAct) legal = bankIdle[bank];
    else if (isRd || isWr) legal = bankOpen[bank];
  end

  assign accessNow  = (isRd || isWr) && legal;
  assign actNow     = isAct && legal;
  assign writeNow   = accessNow && isWr;
  assign streamLive = (colLeft != '0);
  assign cutStream  = accessNow && streamLive;
  assign pipeBusy   = |rdPipe;
  assign rdBeatNow  = accessNow ? isRd : (streamLive && !colWrite);
  assign wrBeats    = wrSingle ? LEN_W'(1) : LEN_W'(BURST_LEN);
  assign pipeShift  = {rdPipe, rdBeatNow};

  assign wrValid       = accessNow ? isWr : (streamLive && colWrite);
  assign rdValid       = rdPipe[CAS_LAT-1] && !writeNow;
  assign burstCut      = cutStream || (writeNow && pipeBusy);
  assign illegalCmd    = (isAct || isRd || isWr) && !legal;
  assign contentionErr = writeNow && pipeBusy && !(&dqmHist);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colLeft  <= '0;
      colWrite <= 1'b0;
      colBank  <= '0;
      rdPipe   <= '0;
      dqmHist  <= '0;
    end else begin
      dqmHist <= {dqmHist[0], dqm};
      rdPipe  <= writeNow ? '0 : pipeShift[CAS_LAT-1:0];
      if (accessNow) begin
        colLeft  <= isRd ? LEN_W'(BURST_LEN - 1) : wrBeats - LEN_W'(1);
        colWrite <= isWr;
        colBank  <= bank;
      end else if (streamLive) begin
        colLeft <= colLeft - LEN_W'(1);
      end
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_strobe
    logic hit;
    assign hit = (bank == BA_W'(b));
    assign strobes[b].openRow   = actNow && hit;
    assign strobes[b].startRdAp = accessNow && isRd && autoPre && hit;
    assign strobes[b].startWrAp = accessNow && isWr && autoPre && hit;
    assign strobes[b].cutBurst  = cutStream && (colBank == BA_W'(b));
  end

endmodule

// File: rtl/sdram_cap_bank.sv
module sdram_cap_bank
  import sdram_cap_pkg::*;
#(
  parameter int CAS_LAT   = 3,
  parameter int BURST_LEN = 4,
  parameter int WR_RECOV  = 2,
  parameter int PRE_TIME  = 3,
  localparam int CNT_W    = $clog2(CAS_LAT + BURST_LEN + WR_RECOV + PRE_TIME + 1),
  localparam int RD_LOAD  = CAS_LAT + BURST_LEN - 2,
  localparam int WR_LOAD  = BURST_LEN + WR_RECOV - 2,
  localparam int WR1_LOAD = WR_RECOV - 1,
  localparam int CUT_LOAD = WR_RECOV - 2,
  localparam int PRE_LOAD = PRE_TIME - 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  bankStrobe_t strobe,
  input  logic        wrSingle,
  output logic        isIdle,
  output logic        isOpen,
  output logic        preStart
);

  bankState_e state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic enterPre;

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    enterPre  = 1'b0;
    unique case (state)
      BK_IDLE: if (strobe.openRow) stateNext = BK_OPEN;
      BK_OPEN: begin
        if (strobe.startRdAp) begin
          stateNext = BK_RDAP;
          cntNext   = CNT_W'(RD_LOAD);
        end else if (strobe.startWrAp) begin
          stateNext = BK_WRAP;
          cntNext   = wrSingle ? CNT_W'(WR1_LOAD) : CNT_W'(WR_LOAD);
        end
      end
      BK_RDAP: begin
        if (strobe.cutBurst || cnt == '0) enterPre = 1'b1;
        else cntNext = cnt - CNT_W'(1);
      end
      BK_WRAP: begin
        if (strobe.cutBurst) cntNext = CNT_W'(CUT_LOAD);
        else if (cnt == '0) enterPre = 1'b1;
        else cntNext = cnt - CNT_W'(1);
      end
      BK_PRECH: begin
        if (cnt == '0) stateNext = BK_IDLE;
        else cntNext = cnt - CNT_W'(1);
      end
      default: stateNext = BK_IDLE;
    endcase
    if (enterPre) begin
      stateNext = BK_PRECH;
      cntNext   = CNT_W'(PRE_LOAD);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= BK_IDLE;
      cnt      <= '0;
      preStart <= 1'b0;
    end else begin
      state    <= stateNext;
      cnt      <= cntNext;
      preStart <= enterPre;
    end
  end

  assign isIdle = (state == BK_IDLE);
  assign isOpen = (state == BK_OPEN);

endmodule

// File: rtl/sdram_cap_tracker.sv
module sdram_cap_tracker
  import sdram_cap_pkg::*;
#(
  parameter int CAS_LAT   = 3,
  parameter int BURST_LEN = 4,
  parameter int WR_RECOV  = 2,
  parameter int PRE_TIME  = 3,
  parameter int NUM_BANKS = 4,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           cmd,
  input  logic [BA_W-1:0]      bank,
  input  logic                 autoPre,
  input  logic                 dqm,
  input  logic                 wrSingle,
  output logic [NUM_BANKS-1:0] bankIdle,
  output logic [NUM_BANKS-1:0] preStart,
  output logic                 rdValid,
  output logic                 wrValid,
  output logic                 burstCut,
  output logic                 illegalCmd,
  output logic                 contentionErr
);

  bankStrobe_t strobes [NUM_BANKS];
  logic [NUM_BANKS-1:0] bankOpen;

  sdram_cap_ctrl #(
    .CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN), .NUM_BANKS(NUM_BANKS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .bank(bank), .autoPre(autoPre),
    .dqm(dqm), .wrSingle(wrSingle), .bankIdle(bankIdle), .bankOpen(bankOpen),
    .strobes(strobes), .rdValid(rdValid), .wrValid(wrValid),
    .burstCut(burstCut), .illegalCmd(illegalCmd), .contentionErr(contentionErr)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sdram_cap_bank #(
      .CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN),
      .WR_RECOV(WR_RECOV), .PRE_TIME(PRE_TIME)
    ) bank_i (
      .clk(clk), .rstN(rstN), .strobe(strobes[b]), .wrSingle(wrSingle),
      .isIdle(bankIdle[b]), .isOpen(bankOpen[b]), .preStart(preStart[b])
    );
  end

endmodule

// File: rtl/sdram_cap_checker.sv
module sdram_cap_checker #(
  parameter int NUM_BANKS = 4,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [1:0]           cmd,
  input logic [BA_W-1:0]      bank,
  input logic [NUM_BANKS-1:0] bankIdle,
  input logic [NUM_BANKS-1:0] preStart,
  input logic                 rdValid,
  input logic                 wrValid,
  input logic                 burstCut,
  input logic                 illegalCmd,
  input logic                 contentionErr
);

  assert_bus_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(rdValid && wrValid));

  assert_contention_on_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    contentionErr |-> wrValid);

  assert_illegal_no_cut_R9: assert property (@(posedge clk) disable iff (!rstN)
    illegalCmd |-> !burstCut && !contentionErr);

  assert_cut_needs_access_R11: assert property (@(posedge clk) disable iff (!rstN)
    burstCut |-> (cmd == 2'b10 || cmd == 2'b11));

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_chk
    assert_prech_not_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
      preStart[g] |-> !bankIdle[g]);

    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rstN)
      (bankIdle[g] && !(cmd == 2'b01 && bank == BA_W'(g))) |=> bankIdle[g]);
  end

endmodule

bind sdram_cap_tracker sdram_cap_checker #(.NUM_BANKS(NUM_BANKS)) chk_i (
  .clk(clk), .rstN(rstN), .cmd(cmd), .bank(bank), .bankIdle(bankIdle),
  .preStart(preStart), .rdValid(rdValid), .wrValid(wrValid),
  .burstCut(burstCut), .illegalCmd(illegalCmd), .contentionErr(contentionErr)
);

// File: tb/sdram_cap_tracker_tb_top.sv
`timescale 1ns/1ps
module sdram_cap_tracker_tb_top;

  localparam logic [1:0] NOP = 2'b00, ACT = 2'b01, RD = 2'b10, WR = 2'b11;
  localparam int K_PRE = 0, K_RD = 1, K_WR = 2, K_CUT = 3, K_ILL = 4, K_CON = 5, K_IDLE = 6;

  typedef struct {
    int    cyc;
    int    kind;
    int    idx;
    bit    val;
    string tag;
  } ev_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] cmd = NOP;
  logic [1:0] bank = '0;
  logic autoPre = 1'b0, dqm = 1'b0, wrSingle = 1'b0;
  logic [3:0] bankIdle, preStart;
  logic rdValid, wrValid, burstCut, illegalCmd, contentionErr;

  int cyc = 0;
  int nChecks = 0;
  int nErrors = 0;
  bit monOn = 1'b0;
  bit done = 1'b0;
  ev_t sbq[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_cap_tracker dut_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .bank(bank), .autoPre(autoPre),
    .dqm(dqm), .wrSingle(wrSingle), .bankIdle(bankIdle), .preStart(preStart),
    .rdValid(rdValid), .wrValid(wrValid), .burstCut(burstCut),
    .illegalCmd(illegalCmd), .contentionErr(contentionErr)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  task automatic push(int c, int kind, int idx, bit val, string tag);
    ev_t e;
    e.cyc = c; e.kind = kind; e.idx = idx; e.val = val; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic tick(logic [1:0] c, int b, bit ap, bit dm, bit ws);
    @(negedge clk);
    cmd = c; bank = 2'(b); autoPre = ap; dqm = dm; wrSingle = ws;
  endtask

  task automatic idleFor(int n);
    for (int i = 0; i < n; i++) tick(NOP, 0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  endtask

  // monitor: pops this cycle's expectations and compares them with the outputs
  initial begin
    forever begin
      logic [3:0] ePre;
      bit eRd, eWr, eCut, eIll, eCon;
      string tPre, tRd, tWr, tCut, tIll, tCon;
      @(negedge clk);
      #8;
      if (monOn) begin
        ePre = '0; eRd = 0; eWr = 0; eCut = 0; eIll = 0; eCon = 0;
        tPre = "R7"; tRd = "R2"; tWr = "R6"; tCut = "R11"; tIll = "R9"; tCon = "R8";
        for (int i = sbq.size() - 1; i >= 0; i--) begin
          if (sbq[i].cyc == cyc) begin
            case (sbq[i].kind)
              K_PRE:  begin ePre[sbq[i].idx] = 1'b1; tPre = sbq[i].tag; end
              K_RD:   begin eRd = 1; tRd = sbq[i].tag; end
              K_WR:   begin eWr = 1; tWr = sbq[i].tag; end
              K_CUT:  begin eCut = 1; tCut = sbq[i].tag; end
              K_ILL:  begin eIll = 1; tIll = sbq[i].tag; end
              K_CON:  begin eCon = 1; tCon = sbq[i].tag; end
              default: check(bankIdle[sbq[i].idx] == sbq[i].val, sbq[i].tag,
                             "bankIdle bit", int'(bankIdle[sbq[i].idx]), int'(sbq[i].val));
            endcase
            sbq.delete(i);
          end
        end
        check(preStart == ePre, tPre, "preStart", int'(preStart), int'(ePre));
        check(rdValid == eRd, tRd, "rdValid", int'(rdValid), int'(eRd));
        check(wrValid == eWr, tWr, "wrValid", int'(wrValid), int'(eWr));
        check(burstCut == eCut, tCut, "burstCut", int'(burstCut), int'(eCut));
        check(illegalCmd == eIll, tIll, "illegalCmd", int'(illegalCmd), int'(eIll));
        check(contentionErr == eCon, tCon, "contentionErr", int'(contentionErr), int'(eCon));
      end
    end
  end

  // watchdog
  initial begin
    #200000;
    nChecks++;
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #8;
    // R1: reset state
    check(bankIdle == 4'hF, "R1", "bankIdle after reset", int'(bankIdle), 15);
    check({preStart, rdValid, wrValid, burstCut, illegalCmd, contentionErr} == '0,
          "R1", "outputs after reset",
          int'({preStart, rdValid, wrValid, burstCut, illegalCmd, contentionErr}), 0);
    monOn = 1'b1;

    // Case A: AP read on bank0 cut by AP read on bank1 (R3, R2, R7, R9, R10)
    tick(ACT, 0, 0, 0, 0); tick(ACT, 1, 0, 0, 0);
    tick(RD, 0, 1, 0, 0); c = cyc;
    for (int k = 3; k <= 8; k++) push(c + k, K_RD, 0, 1, "R3");
    push(c + 2, K_CUT, 0, 1, "R11");
    push(c + 3, K_PRE, 0, 1, "R3");
    push(c + 9, K_PRE, 1, 1, "R7");
    push(c + 4, K_ILL, 0, 1, "R9");
    push(c + 5, K_IDLE, 0, 0, "R10"); push(c + 6, K_IDLE, 0, 1, "R10");
    push(c + 11, K_IDLE, 1, 0, "R10"); push(c + 12, K_IDLE, 1, 1, "R10");
    tick(NOP, 0, 0, 0, 0); tick(RD, 1, 1, 0, 0); tick(NOP, 0, 0, 0, 0);
    tick(ACT, 0, 0, 0, 0);
    idleFor(12);

    // Case B: AP read on bank2 cut by AP write on bank3 with no mask (R4, R8)
    tick(ACT, 2, 0, 0, 0); tick(ACT, 3, 0, 0, 0);
    tick(RD, 2, 1, 0, 0); c = cyc;
    push(c + 2, K_CON, 0, 1, "R8");
    push(c + 2, K_CUT, 0, 1, "R11");
    for (int k = 2; k <= 5; k++) push(c + k, K_WR, 0, 1, "R4");
    push(c + 3, K_PRE, 2, 1, "R4");
    push(c + 8, K_PRE, 3, 1, "R7");
    push(c + 5, K_IDLE, 2, 0, "R10"); push(c + 6, K_IDLE, 2, 1, "R10");
    push(c + 11, K_IDLE, 3, 1, "R10");
    tick(NOP, 0, 0, 0, 0); tick(WR, 3, 1, 0, 0);
    idleFor(12);

    // Case C: AP write on bank0 cut by AP read on bank1 (R5)
    tick(ACT, 0, 0, 0, 0); tick(ACT, 1, 0, 0, 0);
    tick(WR, 0, 1, 0, 0); c = cyc;
    push(c, K_WR, 0, 1, "R5"); push(c + 1, K_WR, 0, 1, "R5");
    push(c + 2, K_CUT, 0, 1, "R11");
    push(c + 4, K_PRE, 0, 1, "R5");
    for (int k = 5; k <= 8; k++) push(c + k, K_RD, 0, 1, "R2");
    push(c + 9, K_PRE, 1, 1, "R7");
    push(c + 7, K_IDLE, 0, 1, "R10");
    tick(NOP, 0, 0, 0, 0); tick(RD, 1, 1, 0, 0);
    idleFor(12);

    // Case D: AP write on bank2 cut by AP write on bank3 (R5, R6)
    tick(ACT, 2, 0, 0, 0); tick(ACT, 3, 0, 0, 0);
    tick(WR, 2, 1, 0, 0); c = cyc;
    for (int k = 0; k <= 4; k++) push(c + k, K_WR, 0, 1, "R6");
    push(c + 1, K_CUT, 0, 1, "R5");
    push(c + 3, K_PRE, 2, 1, "R5");
    push(c + 7, K_PRE, 3, 1, "R7");
    tick(WR, 3, 1, 0, 0);
    idleFor(12);

    // Case E: read cut by write with the mask held two cycles (R8 no flag, R4)
    tick(ACT, 0, 0, 0, 0); tick(ACT, 1, 0, 0, 0);
    tick(RD, 0, 1, 0, 0); c = cyc;
    push(c + 3, K_CUT, 0, 1, "R4");
    for (int k = 3; k <= 6; k++) push(c + k, K_WR, 0, 1, "R4");
    push(c + 4, K_PRE, 0, 1, "R4");
    push(c + 9, K_PRE, 1, 1, "R7");
    tick(NOP, 0, 0, 1, 0); tick(NOP, 0, 0, 1, 0); tick(WR, 1, 1, 0, 0);
    idleFor(12);

    // Case F: single-beat write mode, read keeps its burst (R6, R7)
    tick(ACT, 2, 0, 0, 0); tick(ACT, 3, 0, 0, 0);
    tick(WR, 2, 1, 0, 1); c = cyc;
    push(c, K_WR, 0, 1, "R6");
    push(c + 3, K_PRE, 2, 1, "R7");
    for (int k = 4; k <= 7; k++) push(c + k, K_RD, 0, 1, "R6");
    push(c + 8, K_PRE, 3, 1, "R7");
    tick(RD, 3, 1, 0, 1);
    idleFor(12);

    // Case G: accesses to closed banks are flagged and ignored (R9)
    tick(RD, 0, 0, 0, 0); c = cyc;
    push(c, K_ILL, 0, 1, "R9"); push(c + 1, K_ILL, 0, 1, "R9");
    push(c + 3, K_IDLE, 0, 1, "R9"); push(c + 3, K_IDLE, 1, 1, "R9");
    tick(WR, 1, 0, 0, 0);
    idleFor(6);

    check(sbq.size() == 0, "R2", "unconsumed expectations", sbq.size(), 0);
    finishRun();
  end

endmodule